// File: doc/BRIEF.md
# Keyed-Hash Command Sequencer

This block is the register-mapped control front end of a keyed-hash (HMAC-style) unit. Software talks to it through a single word-addressed write port and a combinational read port. It opens a session with a start command and then picks a routing purpose and a hardware key slot. A finish strobe commits that configuration. The block checks the purpose against a small table of key tags and flags an error on a mismatch. The message then arrives in 512-bit blocks of sixteen 32-bit words. Each block is marked loaded and then closed with one of four commands, and the block hands it to an external compression engine over a request/done handshake.

Each close command has its own meaning. "One" means this is the final block. "Continue" means more blocks follow. "Pad" means only one more block follows, and software has already padded it. "End" makes the block generate and hash a padding block of its own. That block holds 0x80, then zeros, then a 64-bit big-endian bit count that includes the leading 512-bit inner-key block. A software-bound digest shows up in an eight-word read window. A digest bound for the signature unit or the debug-unlock path goes out on a downstream key port with per-consumer valid flags, and each flag has its own invalidate strobe.

The FSM has five states. ST_IDLE goes to ST_CONFIG on start. ST_CONFIG goes to ST_WAIT_BLOCK on an accepted finish strobe, or back to ST_IDLE on a rejected one. ST_WAIT_BLOCK goes to ST_HASHING on a legal close. ST_HASHING does one of three things on engine done: it returns to ST_WAIT_BLOCK after continue or pad, it stays in ST_HASHING to send the generated padding block after end, or it goes to ST_DONE after the final block. ST_DONE goes to ST_IDLE only through result-clear. Result-clear takes every state to ST_IDLE.

Top module: `kh_seq`

## Requirements
- R1: After reset the error word (address 0x0C) and busy word (0x0D) read 0, every result word (0x20-0x27) reads 0, and eng_req, sig_valid and dbg_valid are low.
- R2: A write to 0x03 in ST_CONFIG accepts the configuration only when two conditions hold: the purpose (written at 0x01, low 4 bits) is one of 5, 6, 7 or 8, and it equals the tag of the slot written at 0x02. The default tags are slot0=8, slot1=7, slot2=6, slot3=5, slot4=8, slot5=0, and slot values of 6 or more are invalid. On acceptance the error word reads 0. Otherwise it reads 1 and the block returns to ST_IDLE, where a start write at 0x00 clears the error.
- R3: A command outside its legal state is ignored and sets the error word to 1. This covers a start outside ST_IDLE, purpose, slot or finish writes outside ST_CONFIG, message words (0x10-0x1F) or the load strobe (0x04) outside ST_WAIT_BLOCK, and a close command with no loaded block.
- R4: Close-one (0x05) issues exactly one engine request carrying the block. Word i (address 0x10+i) sits at bits 511-32i down. After done the block enters ST_DONE.
- R5: Continue (0x06) hashes the block and returns to ST_WAIT_BLOCK. eng_first is high only on the first request of a message.
- R6: After pad (0x07), the next block accepts only close-one. Continue, pad or end is ignored with error 1 and sends no request.
- R7: End (0x08) hashes the block and then sends a second request carrying 0x80, zeros, and the 64-bit big-endian value (n+1)*512 in the low bits, where n is the number of message blocks.
- R8: The busy word reads 1 from the cycle after an accepted close until the final engine done, and eng_req is asserted only in ST_HASHING.
- R9: For purpose 8 the result words read the digest, with word i equal to bits 255-32i down. For purposes 5, 6 and 7 they read 0.
- R10: On completion, purpose 7 sets sig_valid, 6 sets dbg_valid, and 5 sets both, with down_key equal to the digest. Purpose 8 sets neither.
- R11: A write to 0x0A clears sig_valid and a write to 0x0B clears dbg_valid. down_key reads 0 once both are low.
- R12: Writing 2 to 0x09 returns the block to ST_IDLE from any state and zeroes the result. Other values at 0x09 have no effect.
- R13: eng_req is a one-cycle pulse, and an eng_done outside ST_HASHING is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| eng_req | output | 1 | One-cycle request to the compression engine |
| eng_first | output | 1 | Request is the first block of a message |
| eng_key_slot | output | KW | Selected hardware key slot |
| eng_block | output | 512 | Block to compress |
| eng_done | input | 1 | Engine completion pulse |
| eng_digest | input | 256 | Running digest from the engine |
| sig_valid | output | 1 | Digest available to the signature unit |
| dbg_valid | output | 1 | Digest available to the debug-unlock path |
| down_key | output | 256 | Digest for downstream consumers, zero when neither valid |

## Verification
The bench targets the generated padding block. A miscounted length, or one that leaves out the inner-key block, shows up as a wrong second engine block and a wrong final digest. It also drives pad followed by continue. A design that did not lock the final block to close-one would issue an extra engine request and corrupt the chain. It drives result-clear in the middle of a hash with the engine's done arriving afterwards. A design that honoured a late done would jump to ST_DONE or publish a stale digest. Mismatched, out-of-range and forbidden purpose and slot pairs are exercised as well. A loose check would wrongly accept them, and software could then read keys meant for other hardware.

// File: rtl/kh_pkg.sv
package kh_pkg;
    localparam int DW        = 32;
    localparam int BLK_W     = 512;
    localparam int DIG_W     = 256;
    localparam int AW        = 6;
    localparam int MSG_WORDS = BLK_W / DW;
    localparam int RES_WORDS = DIG_W / DW;
    localparam int RSEL_W    = $clog2(RES_WORDS);

    typedef enum logic [2:0] {
        ST_IDLE, ST_CONFIG, ST_WAIT_BLOCK, ST_HASHING, ST_DONE
    } kh_state_e;

    typedef enum logic [1:0] {CL_ONE, CL_CONT, CL_PAD, CL_END} kh_close_e;

    localparam logic [AW-1:0] A_START   = 6'h00;
    localparam logic [AW-1:0] A_PURP    = 6'h01;
    localparam logic [AW-1:0] A_SLOT    = 6'h02;
    localparam logic [AW-1:0] A_CFG     = 6'h03;
    localparam logic [AW-1:0] A_LOAD    = 6'h04;
    localparam logic [AW-1:0] A_ONE     = 6'h05;
    localparam logic [AW-1:0] A_CONT    = 6'h06;
    localparam logic [AW-1:0] A_PAD     = 6'h07;
    localparam logic [AW-1:0] A_END     = 6'h08;
    localparam logic [AW-1:0] A_CLR     = 6'h09;
    localparam logic [AW-1:0] A_INV_SIG = 6'h0A;
    localparam logic [AW-1:0] A_INV_DBG = 6'h0B;
    localparam logic [AW-1:0] A_ERR     = 6'h0C;
    localparam logic [AW-1:0] A_BUSY    = 6'h0D;
    localparam logic [AW-1:0] A_MSG     = 6'h10;
    localparam logic [AW-1:0] A_RES     = 6'h20;

    localparam logic [3:0] P_ALL = 4'd5;
    localparam logic [3:0] P_DBG = 4'd6;
    localparam logic [3:0] P_SIG = 4'd7;
    localparam logic [3:0] P_SW  = 4'd8;
endpackage

// File: rtl/kh_cfg_check.sv
module kh_cfg_check
    import kh_pkg::*;
#(
    parameter int                 NKEYS    = 6,
    parameter logic [4*NKEYS-1:0] KEY_TAGS = 24'h085678
) (
    input  logic [3:0] purpose,
    input  logic [7:0] key_sel,
    output logic       cfg_ok
);
    logic [3:0] tags [NKEYS];

    generate
        for (genvar g = 0; g < NKEYS; g++) begin : g_tag
            assign tags[g] = KEY_TAGS[4*g +: 4];
        end
    endgenerate

    always_comb begin
        logic tag_hit;
        tag_hit = 1'b0;
        for (int i = 0; i < NKEYS; i++) begin
            if (key_sel == 8'(i)) tag_hit = (tags[i] == purpose);
        end
        cfg_ok = tag_hit && (purpose inside {P_ALL, P_DBG, P_SIG, P_SW});
    end
endmodule

// File: rtl/kh_pad_gen.sv
module kh_pad_gen
    import kh_pkg::*;
#(
    parameter int CNTW = 16
) (
    input  logic [CNTW-1:0]  blk_cnt,
    output logic [BLK_W-1:0] pad_block
);
    localparam int LEN_W = 64;
    localparam int SH    = $clog2(BLK_W);
    localparam int ZW    = BLK_W - 8 - LEN_W;

    logic [CNTW:0]      total;
    logic [LEN_W-1:0]   bit_len;

    // inner-key block counts as one extra block
    assign total     = {1'b0, blk_cnt} + {{CNTW{1'b0}}, 1'b1};
    assign bit_len   = {{(LEN_W-CNTW-1-SH){1'b0}}, total, {SH{1'b0}}};
    assign pad_block = {8'h80, {ZW{1'b0}}, bit_len};
endmodule

// File: rtl/kh_result_win.sv
module kh_result_win
    import kh_pkg::*;
(
    input  logic [DIG_W-1:0]  result,
    input  logic [RSEL_W-1:0] sel,
    input  logic              visible,
    output logic [DW-1:0]     word
);
    logic [DW-1:0] words [RES_WORDS];

    generate
        for (genvar g = 0; g < RES_WORDS; g++) begin : g_word
            assign words[g] = result[DIG_W-1-DW*g -: DW];
        end
    endgenerate

    assign word = visible ? words[sel] : '0;
endmodule

// File: rtl/kh_seq.sv
module kh_seq
    import kh_pkg::*;
#(
    parameter int                 NKEYS    = 6,
    parameter logic [4*NKEYS-1:0] KEY_TAGS = 24'h085678,
    parameter int                 CNTW     = 16,
    parameter int                 KW       = (NKEYS > 1) ? $clog2(NKEYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             eng_req,
    output logic             eng_first,
    output logic [KW-1:0]    eng_key_slot,
    output logic [BLK_W-1:0] eng_block,
    input  logic             eng_done,
    input  logic [DIG_W-1:0] eng_digest,
    output logic             sig_valid,
    output logic             dbg_valid,
    output logic [DIG_W-1:0] down_key
);
    kh_state_e        st, st_nx;
    kh_close_e        mode, close_sel;
    logic [3:0]       purpose;
    logic [7:0]       key_sel;
    logic             err, blk_full, pad_phase, last_only;
    logic [CNTW-1:0]  blk_cnt;
    logic [DIG_W-1:0] result, dkey;
    logic [BLK_W-1:0] msg, pad_block;
    logic [DW-1:0]    win_word;
    logic             cfg_ok, in_idle, in_hash;

    logic wr_start, wr_purp, wr_slot, wr_cfg, wr_load, wr_msg, wr_one, wr_cont;
    logic wr_pad, wr_end, abort, close_hit, close_ok, take_close;
    logic hash_done, need_pad, final_done, seq_err, to_sig, to_dbg;

    assign in_idle   = (st == ST_IDLE);
    assign in_hash   = (st == ST_HASHING);
    assign wr_start  = reg_we && reg_addr == A_START;
    assign wr_purp   = reg_we && reg_addr == A_PURP;
    assign wr_slot   = reg_we && reg_addr == A_SLOT;
    assign wr_cfg    = reg_we && reg_addr == A_CFG;
    assign wr_load   = reg_we && reg_addr == A_LOAD;
    assign wr_msg    = reg_we && reg_addr[AW-1:4] == A_MSG[AW-1:4];
    assign wr_one    = reg_we && reg_addr == A_ONE;
    assign wr_cont   = reg_we && reg_addr == A_CONT;
    assign wr_pad    = reg_we && reg_addr == A_PAD;
    assign wr_end    = reg_we && reg_addr == A_END;
    assign abort     = reg_we && reg_addr == A_CLR && reg_wdata == 32'd2;
    assign close_hit = wr_one || wr_cont || wr_pad || wr_end;
    assign close_sel = wr_one ? CL_ONE : wr_cont ? CL_CONT : wr_pad ? CL_PAD : CL_END;
    assign close_ok  = (st == ST_WAIT_BLOCK) && blk_full && (!last_only || wr_one);
    assign take_close = close_hit && close_ok && !abort;

    assign hash_done  = in_hash && eng_done;
    assign need_pad   = hash_done && mode == CL_END && !pad_phase;
    assign final_done = hash_done && (mode == CL_ONE || (mode == CL_END && pad_phase));

    assign seq_err = (wr_start && !in_idle)
                  || ((wr_purp || wr_slot || wr_cfg) && st != ST_CONFIG)
                  || ((wr_msg || wr_load) && st != ST_WAIT_BLOCK)
                  || (close_hit && !close_ok);

    assign to_sig = (purpose == P_SIG) || (purpose == P_ALL);
    assign to_dbg = (purpose == P_DBG) || (purpose == P_ALL);

    kh_cfg_check #(.NKEYS(NKEYS), .KEY_TAGS(KEY_TAGS)) u_cfg (
        .purpose(purpose), .key_sel(key_sel), .cfg_ok(cfg_ok)
    );

    kh_pad_gen #(.CNTW(CNTW)) u_pad (.blk_cnt(blk_cnt), .pad_block(pad_block));

    kh_result_win u_win (
        .result(result), .sel(reg_addr[RSEL_W-1:0]),
        .visible(st == ST_DONE && purpose == P_SW), .word(win_word)
    );

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:       if (wr_start) st_nx = ST_CONFIG;
            ST_CONFIG:     if (wr_cfg) st_nx = cfg_ok ? ST_WAIT_BLOCK : ST_IDLE;
            ST_WAIT_BLOCK: if (take_close) st_nx = ST_HASHING;
            ST_HASHING:    if (final_done) st_nx = ST_DONE;
                           else if (hash_done && !need_pad) st_nx = ST_WAIT_BLOCK;
            ST_DONE:       st_nx = ST_DONE;
        endcase
        if (abort) st_nx = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= CL_ONE;    purpose <= '0;  key_sel <= '0;   err <= 1'b0;
            blk_full <= 1'b0;  pad_phase <= 1'b0; last_only <= 1'b0;
            blk_cnt <= '0;     result <= '0;   dkey <= '0;      msg <= '0;
            eng_req <= 1'b0;   sig_valid <= 1'b0; dbg_valid <= 1'b0;
        end else begin
            eng_req <= (take_close || need_pad) && !abort;
            if (wr_start && in_idle) err <= 1'b0;
            if (wr_purp && st == ST_CONFIG) purpose <= reg_wdata[3:0];
            if (wr_slot && st == ST_CONFIG) key_sel <= reg_wdata[7:0];
            if (wr_cfg && st == ST_CONFIG) begin
                err <= !cfg_ok;
                blk_cnt <= '0; blk_full <= 1'b0; pad_phase <= 1'b0; last_only <= 1'b0;
            end
            if (seq_err) err <= 1'b1;
            if (wr_msg && st == ST_WAIT_BLOCK)
                msg[BLK_W-1-DW*int'(reg_addr[3:0]) -: DW] <= reg_wdata;
            if (wr_load && st == ST_WAIT_BLOCK) blk_full <= 1'b1;
            if (take_close) begin
                mode <= close_sel;
                last_only <= 1'b0;
            end
            if (hash_done && !pad_phase) begin
                blk_cnt  <= blk_cnt + 1'b1;
                blk_full <= 1'b0;
                if (mode == CL_PAD) last_only <= 1'b1;
            end
            if (need_pad) pad_phase <= 1'b1;
            if (final_done && !abort) begin
                result <= (purpose == P_SW) ? eng_digest : '0;
                dkey   <= eng_digest;
                if (to_sig) sig_valid <= 1'b1;
                if (to_dbg) dbg_valid <= 1'b1;
            end
            if (reg_we && reg_addr == A_INV_SIG) sig_valid <= 1'b0;
            if (reg_we && reg_addr == A_INV_DBG) dbg_valid <= 1'b0;
            if (abort) begin
                result <= '0; blk_full <= 1'b0; pad_phase <= 1'b0;
                last_only <= 1'b0; blk_cnt <= '0;
            end
        end
    end

    assign eng_first    = (blk_cnt == '0) && !pad_phase;
    assign eng_key_slot = key_sel[KW-1:0];
    assign eng_block    = pad_phase ? pad_block : msg;
    assign down_key     = (sig_valid || dbg_valid) ? dkey : '0;

    always_comb begin
        if (reg_addr == A_ERR)                          reg_rdata = {{(DW-1){1'b0}}, err};
        else if (reg_addr == A_BUSY)                    reg_rdata = {{(DW-1){1'b0}}, in_hash};
        else if (reg_addr[AW-1:RSEL_W] == A_RES[AW-1:RSEL_W]) reg_rdata = win_word;
        else                                            reg_rdata = '0;
    end
endmodule

// File: rtl/kh_seq_chk.sv
module kh_seq_chk
    import kh_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          eng_req,
    input logic          sig_valid,
    input logic          dbg_valid,
    input logic          in_idle,
    input logic          in_hash,
    input logic [3:0]    purpose
);
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_CLR && reg_wdata == 32'd2) |=> in_idle); // R12

    AST_REQ_ONLY_HASHING: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> in_hash); // R8

    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req); // R13

    AST_SIG_INVALIDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_INV_SIG) |=> !sig_valid); // R11

    AST_DBG_INVALIDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_INV_DBG) |=> !dbg_valid); // R11

    AST_SIG_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_valid) |-> (purpose == P_SIG || purpose == P_ALL)); // R10

    AST_DBG_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_valid) |-> (purpose == P_DBG || purpose == P_ALL)); // R10
endmodule

bind kh_seq kh_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .eng_req(eng_req), .sig_valid(sig_valid),
    .dbg_valid(dbg_valid), .in_idle(in_idle), .in_hash(in_hash), .purpose(purpose)
);

// File: tb/sim_kh_seq.sv
module sim_kh_seq;
    import kh_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [AW-1:0]    reg_addr = '0;
    logic [DW-1:0]    reg_wdata = '0;
    logic [DW-1:0]    reg_rdata;
    logic             eng_req, eng_first;
    logic [2:0]       eng_key_slot;
    logic [BLK_W-1:0] eng_block;
    logic             eng_done = 1'b0;
    logic [DIG_W-1:0] eng_digest = '0;
    logic             sig_valid, dbg_valid;
    logic [DIG_W-1:0] down_key;

    kh_seq u0 (.*);

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    // engine mock log
    logic [BLK_W-1:0] log_blk [64];
    bit               log_first [64];
    int               nlog = 0;
    int               force_lat = 0;
    logic [DIG_W-1:0] mchain = '0;

    function automatic logic [DIG_W-1:0] mix(logic [DIG_W-1:0] c, logic [BLK_W-1:0] b, bit first);
        logic [DIG_W-1:0] s;
        s = first ? {8{32'h6A09E667}} : c;
        return {s[DIG_W-2:0], s[DIG_W-1]} ^ b[BLK_W-1:DIG_W] ^ {b[DIG_W/2-1:0], b[DIG_W-1:DIG_W/2]};
    endfunction

    function automatic logic [BLK_W-1:0] exp_pad(int n);
        logic [63:0] len;
        len = 64'(n + 1) * 64'd512;
        return {8'h80, 440'b0, len};
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            while (eng_req) begin
                if (nlog < 64) begin
                    log_blk[nlog] = eng_block;
                    log_first[nlog] = eng_first;
                end
                nlog++;
                mchain = mix(mchain, eng_block, eng_first);
                repeat (force_lat != 0 ? force_lat : 1 + $urandom_range(3)) @(negedge clk);
                eng_digest = mchain;
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0;
            end
        end
    end

    task automatic chk(bit ok, string req, logic [DIG_W-1:0] act, logic [DIG_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rd_result(output logic [DIG_W-1:0] r);
        logic [DW-1:0] w;
        for (int i = 0; i < RES_WORDS; i++) begin
            rd(A_RES + 6'(i), w);
            r[DIG_W-1-DW*i -: DW] = w;
        end
    endtask

    task automatic wait_idle();
        logic [DW-1:0] b;
        for (int i = 0; i < 200; i++) begin
            rd(A_BUSY, b);
            if (b == 0) return;
            @(negedge clk);
        end
        chk(0, "R8 busy never cleared", 1, 0);
    endtask

    task automatic open_cfg(logic [3:0] p, logic [7:0] k);
        wr(A_START, 1);
        wr(A_PURP, 32'(p));
        wr(A_SLOT, 32'(k));
        wr(A_CFG, 1);
    endtask

    task automatic load_block(output logic [BLK_W-1:0] b);
        for (int i = 0; i < MSG_WORDS; i++) begin
            logic [DW-1:0] w;
            w = $urandom;
            b[BLK_W-1-DW*i -: DW] = w;
            wr(A_MSG + 6'(i), w);
        end
        wr(A_LOAD, 1);
    endtask

    function automatic logic [7:0] slot_for(logic [3:0] p);
        case (p)
            P_SW:  return 8'd0;
            P_SIG: return 8'd1;
            P_DBG: return 8'd2;
            default: return 8'd3;
        endcase
    endfunction

    // style 0: continue..one, 1: pad before last, 2: end
    task automatic run_msg(logic [3:0] p, int n, int style, output logic [DIG_W-1:0] ch);
        logic [BLK_W-1:0] b;
        logic [DW-1:0] v;
        logic [DIG_W-1:0] r;
        int nexp;
        open_cfg(p, slot_for(p));
        rd(A_ERR, v);
        chk(v == 0, "R2 good config err", v, 0);
        nlog = 0;
        ch = '0;
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] cmd;
            load_block(b);
            ch = mix(ch, b, i == 0);
            if (i == n - 1) cmd = (style == 2) ? A_END : A_ONE;
            else if (style == 1 && i == n - 2) cmd = A_PAD;
            else cmd = A_CONT;
            wr(cmd, 1);
            rd(A_BUSY, v);
            chk(v == 1, "R8 busy after close", v, 1);
            wait_idle();
        end
        nexp = n;
        if (style == 2) begin
            ch = mix(ch, exp_pad(n), 0);
            nexp = n + 1;
            chk(log_blk[n] == exp_pad(n), "R7 padding block", log_blk[n][255:0], exp_pad(n));
        end
        chk(nlog == nexp, "R13 R4 request count", nlog, nexp);
        chk(log_first[0] == 1, "R5 first flag on block 0", log_first[0], 1);
        if (n > 1) chk(log_first[n-1] == 0, "R5 first flag low later", log_first[n-1], 0);
        rd_result(r);
        if (p == P_SW) begin
            chk(r == ch, "R9 R4 result window", r, ch);
            chk(!sig_valid && !dbg_valid, "R10 sw purpose no downstream", {sig_valid, dbg_valid}, 0);
        end else begin
            chk(r == 0, "R9 window hidden", r, 0);
            chk(sig_valid == (p == P_SIG || p == P_ALL), "R10 sig route", sig_valid, p);
            chk(dbg_valid == (p == P_DBG || p == P_ALL), "R10 dbg route", dbg_valid, p);
            chk(down_key == ch, "R10 down_key", down_key, ch);
        end
    endtask

    task automatic finish_msg();
        wr(A_CLR, 2);
        wr(A_INV_SIG, 1);
        wr(A_INV_DBG, 1);
    endtask

    initial begin
        logic [DW-1:0] v;
        logic [DIG_W-1:0] ch, r;
        logic [BLK_W-1:0] b;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_ERR, v);  chk(v == 0, "R1 err after reset", v, 0);
        rd(A_BUSY, v); chk(v == 0, "R1 busy after reset", v, 0);
        rd(A_RES, v);  chk(v == 0, "R1 result after reset", v, 0);
        chk(!eng_req && !sig_valid && !dbg_valid, "R1 outputs low", {eng_req, sig_valid, dbg_valid}, 0);

        // R4 R9 one block to software
        run_msg(P_SW, 1, 0, ch);
        // R12 clear with another value is ignored
        wr(A_CLR, 1);
        rd_result(r);
        chk(r == ch, "R12 clear value 1 ignored", r, ch);
        finish_msg();
        rd_result(r);
        chk(r == 0, "R12 clear zeroes result", r, 0);

        // R2 bad configurations
        open_cfg(P_SW, 8'd1);
        rd(A_ERR, v); chk(v == 1, "R2 purpose/tag mismatch", v, 1);
        wr(A_START, 1);
        rd(A_ERR, v); chk(v == 0, "R2 returned to idle", v, 0);
        wr(A_CLR, 2);
        open_cfg(P_SW, 8'd9);
        rd(A_ERR, v); chk(v == 1, "R2 slot out of range", v, 1);
        open_cfg(4'd0, 8'd5);
        rd(A_ERR, v); chk(v == 1, "R2 forbidden purpose code", v, 1);

        // R3 out-of-sequence commands
        wr(A_CLR, 2);
        wr(A_MSG, 32'h1);
        rd(A_ERR, v); chk(v == 1, "R3 word in idle", v, 1);
        open_cfg(P_SW, 8'd4);
        rd(A_ERR, v); chk(v == 0, "R3 start clears err", v, 0);
        nlog = 0;
        wr(A_ONE, 1);
        rd(A_ERR, v); chk(v == 1, "R3 close before load", v, 1);
        rd(A_BUSY, v); chk(v == 0, "R3 close ignored busy", v, 0);
        chk(nlog == 0, "R3 no request", nlog, 0);
        load_block(b);
        wr(A_ONE, 1);
        wait_idle();
        rd_result(r);
        chk(r == mix('0, b, 1), "R3 recovers to one-block", r, mix('0, b, 1));
        finish_msg();

        // R6 pad then continue is rejected
        open_cfg(P_SW, 8'd0);
        nlog = 0;
        load_block(b);
        ch = mix('0, b, 1);
        wr(A_PAD, 1);
        wait_idle();
        load_block(b);
        wr(A_CONT, 1);
        rd(A_ERR, v); chk(v == 1, "R6 continue after pad", v, 1);
        rd(A_BUSY, v); chk(v == 0, "R6 no hashing", v, 0);
        chk(nlog == 1, "R6 no extra request", nlog, 1);
        wr(A_ONE, 1);
        wait_idle();
        ch = mix(ch, b, 0);
        rd_result(r);
        chk(r == ch, "R6 final after pad", r, ch);
        finish_msg();

        // R7 end with one and two blocks
        run_msg(P_SW, 1, 2, ch); finish_msg();
        run_msg(P_SIG, 2, 2, ch); finish_msg();

        // R11 invalidation with purpose 5
        run_msg(P_ALL, 2, 1, ch);
        wr(A_CLR, 2);
        wr(A_INV_SIG, 1);
        chk(!sig_valid && dbg_valid, "R11 sig invalidated only", {sig_valid, dbg_valid}, 1);
        chk(down_key == ch, "R11 key held for dbg", down_key, ch);
        wr(A_INV_DBG, 1);
        chk(!dbg_valid && down_key == 0, "R11 key cleared", down_key, 0);

        // R12 R13 abort mid-hash, late done ignored
        force_lat = 4;
        open_cfg(P_SW, 8'd0);
        load_block(b);
        wr(A_ONE, 1);
        wr(A_CLR, 2);
        rd(A_BUSY, v); chk(v == 0, "R12 abort clears busy", v, 0);
        repeat (10) @(negedge clk);
        rd(A_BUSY, v); chk(v == 0, "R13 late done ignored", v, 0);
        rd_result(r); chk(r == 0, "R13 no result from late done", r, 0);
        wr(A_START, 1);
        rd(A_ERR, v); chk(v == 0, "R12 idle after abort", v, 0);
        wr(A_CLR, 2);
        force_lat = 0;

        // random messages
        for (int t = 0; t < 20; t++) begin
            logic [3:0] p;
            int n, s;
            p = 4'(5 + $urandom_range(3));
            n = 1 + $urandom_range(3);
            s = $urandom_range(2);
            if (s == 1 && n < 2) n = 2;
            run_msg(p, n, s, ch);
            finish_msg();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R13 watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule